// File: doc/BRIEF.md
# Ternary Route Lookup Table

This block resolves a destination address to a next-hop code in one pass over a small table of ternary entries. Each entry holds a stored pattern, a care mask, a valid flag and a next-hop field. A care bit of 1 means the key bit must equal the stored bit. A care bit of 0 makes that position a wildcard that accepts either key value. Every entry compares itself against the key in the same cycle. A fixed-priority pick then chooses the lowest-numbered matching entry.

Longest-prefix routing comes from the way the table is loaded. The loader places longer prefixes at lower indices. The block itself never reorders anything. Entries are installed or removed through a single write port. The registered result (hit flag, winning index and next hop) appears on the clock edge after the key is presented.

Top module: `tcam_lpm`

## Requirements
- R1: After reset every entry is invalid and res_vld, res_hit, res_idx and res_nh are all 0. A search made before any write therefore misses, even for a key of all zeros.
- R2: An entry matches when it is valid and, for every bit where its care mask is 1, the key bit equals the stored bit. Where the care mask is 0, the bit matches either key value, so an all-zero mask matches every key.
- R3: When several entries match, the entry with the lowest index wins.
- R4: When no entry matches, res_hit is 0 and both res_nh and res_idx are 0.
- R5: res_vld is srch_en delayed by exactly one clock. The result fields belong to the key that was present on that earlier edge.
- R6: A search that starts in the same cycle as a write sees the table as it was before that write. A search one cycle later sees the new contents.
- R7: A write with wr_valid at 0 removes the addressed entry. That entry then never matches, whatever its mask.
- R8: On a hit, res_idx reports the winning entry's index and res_nh reports that entry's stored next hop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| srch_en | input | 1 | Key on srch_key is a lookup request |
| srch_key | input | KEY_W | Address to look up |
| wr_en | input | 1 | Write the entry addressed by wr_idx |
| wr_idx | input | IDX_W | Entry to write |
| wr_valid | input | 1 | Valid flag to store (0 removes the entry) |
| wr_value | input | KEY_W | Stored pattern |
| wr_care | input | KEY_W | Care mask, 1 = bit must match |
| wr_nh | input | NH_W | Next hop to store |
| res_vld | output | 1 | Result belongs to a lookup from the previous cycle |
| res_hit | output | 1 | Some valid entry matched |
| res_idx | output | IDX_W | Winning entry index, 0 on miss |
| res_nh | output | NH_W | Winning next hop, 0 on miss |

## Verification
A table write and a lookup can land in the same cycle, and they can target the same entry. The bench provokes this by raising wr_en and srch_en together. The write installs an entry that would match the key being searched. The bench expects a miss on that first lookup, then repeats the lookup one cycle later and expects a hit with the new next hop and index. An entry removal is also raised while the key matches that entry, and the following lookup must fall through to the next lower-priority entry.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  localparam int unsigned KEY_MAX = 64;

  // One ternary compare: the entry hits when valid and every cared-for bit agrees.
  function automatic logic tern_hit(input logic [KEY_MAX-1:0] key,
                                    input logic [KEY_MAX-1:0] stored,
                                    input logic [KEY_MAX-1:0] care,
                                    input logic               valid);
    logic [KEY_MAX-1:0] diff;
    diff = (key ^ stored) & care;
    return valid && (diff == '0);
  endfunction

endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned KEY_W   = 32,
  parameter int unsigned NH_W    = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_care,
  input  logic [NH_W-1:0]  wr_nh,
  input  logic [KEY_W-1:0] key,
  output logic [ENTRIES-1:0] match_vec,
  output logic [NH_W-1:0]  nh_tbl [ENTRIES]
);
  import tcam_pkg::*;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic             vld_q;
    logic [KEY_W-1:0] val_q;
    logic [KEY_W-1:0] care_q;
    logic [NH_W-1:0]  nh_q;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        val_q  <= '0;
        care_q <= '0;
        nh_q   <= '0;
      end else if (sel) begin
        vld_q  <= wr_valid;
        val_q  <= wr_value;
        care_q <= wr_care;
        nh_q   <= wr_nh;
      end
    end

    assign match_vec[g] = tern_hit(KEY_MAX'(key), KEY_MAX'(val_q),
                                   KEY_MAX'(care_q), vld_q);
    assign nh_tbl[g] = nh_q;
  end

endmodule

// File: rtl/tcam_pick.sv
module tcam_pick #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned NH_W    = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [NH_W-1:0]    nh_tbl [ENTRIES],
  output logic               any_match,
  output logic [IDX_W-1:0]   win_idx,
  output logic [NH_W-1:0]    win_nh
);

  // Scan from the top down so the lowest set index is the last one kept.
  always_comb begin
    any_match = 1'b0;
    win_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_match = 1'b1;
        win_idx   = IDX_W'(i);
      end
    end
  end

  assign win_nh = any_match ? nh_tbl[win_idx] : '0;

endmodule

// File: rtl/tcam_lpm.sv
module tcam_lpm #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned KEY_W   = 32,
  parameter int unsigned NH_W    = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srch_en,
  input  logic [KEY_W-1:0] srch_key,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_care,
  input  logic [NH_W-1:0]  wr_nh,
  output logic             res_vld,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx,
  output logic [NH_W-1:0]  res_nh
);

  logic [ENTRIES-1:0] match_vec;
  logic [NH_W-1:0]    nh_tbl [ENTRIES];
  logic               any_match;
  logic [IDX_W-1:0]   win_idx;
  logic [NH_W-1:0]    win_nh;

  tcam_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .NH_W(NH_W), .IDX_W(IDX_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .wr_value  (wr_value),
    .wr_care   (wr_care),
    .wr_nh     (wr_nh),
    .key       (srch_key),
    .match_vec (match_vec),
    .nh_tbl    (nh_tbl)
  );

  tcam_pick #(.ENTRIES(ENTRIES), .NH_W(NH_W), .IDX_W(IDX_W)) u_pick (
    .match_vec (match_vec),
    .nh_tbl    (nh_tbl),
    .any_match (any_match),
    .win_idx   (win_idx),
    .win_nh    (win_nh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      res_hit <= 1'b0;
      res_idx <= '0;
      res_nh  <= '0;
    end else begin
      res_vld <= srch_en;
      res_hit <= any_match;
      res_idx <= any_match ? win_idx : '0;
      res_nh  <= win_nh;
    end
  end

endmodule

// File: rtl/tcam_lpm_chk.sv
module tcam_lpm_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned NH_W    = 8,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srch_en,
  input logic               wr_en,
  input logic               wr_valid,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [ENTRIES-1:0] match_vec,
  input logic               any_match,
  input logic [IDX_W-1:0]   win_idx,
  input logic               res_vld,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_idx,
  input logic [NH_W-1:0]    res_nh
);

  logic [ENTRIES-1:0] below_win;
  assign below_win = (ENTRIES'(1) << win_idx) - ENTRIES'(1);

  assert_vld_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    srch_en |=> res_vld);
  assert_vld_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !res_vld);
  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_nh == '0) && (res_idx == '0));
  assert_no_match_miss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_match |=> !res_hit);
  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |-> match_vec[win_idx] && ((match_vec & below_win) == '0));
  assert_hit_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_match |=> res_hit && (res_idx == $past(win_idx)));
  assert_removed_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_valid) |=> !match_vec[$past(wr_idx)]);

endmodule

bind tcam_lpm tcam_lpm_chk #(.ENTRIES(ENTRIES), .NH_W(NH_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .srch_en   (srch_en),
  .wr_en     (wr_en),
  .wr_valid  (wr_valid),
  .wr_idx    (wr_idx),
  .match_vec (match_vec),
  .any_match (any_match),
  .win_idx   (win_idx),
  .res_vld   (res_vld),
  .res_hit   (res_hit),
  .res_idx   (res_idx),
  .res_nh    (res_nh)
);

// File: tb/test_tcam_lpm.sv
module test_tcam_lpm;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 16;
  localparam int KEY_W = 32;
  localparam int NH_W = 8;
  localparam int IDX_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srch_en = 1'b0;
  logic [KEY_W-1:0] srch_key = '0;
  logic wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic wr_valid = 1'b0;
  logic [KEY_W-1:0] wr_value = '0;
  logic [KEY_W-1:0] wr_care = '0;
  logic [NH_W-1:0] wr_nh = '0;
  logic res_vld, res_hit;
  logic [IDX_W-1:0] res_idx;
  logic [NH_W-1:0] res_nh;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcam_lpm #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .NH_W(NH_W)) i_tcam_lpm (
    .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .srch_key(srch_key),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_value(wr_value),
    .wr_care(wr_care), .wr_nh(wr_nh),
    .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx), .res_nh(res_nh)
  );

  typedef struct packed {
    logic [31:0] key;
    logic        hit;
    logic [7:0]  nh;
    logic [3:0]  idx;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{32'h0A010203, 1'b1, 8'd3,  4'd0},  // R3: /24, /16 and /8 all match
    '{32'h0A0105FF, 1'b1, 8'd5,  4'd1},  // R3: /16 beats /8
    '{32'h0A7F0000, 1'b1, 8'd7,  4'd2},
    '{32'hC0A8ABCD, 1'b1, 8'd9,  4'd3},  // R2: low half wildcard
    '{32'h0B000005, 1'b1, 8'd11, 4'd4},  // R2: non-prefix ternary entry
    '{32'h0B000006, 1'b0, 8'd0,  4'd0},  // R4: miss
    '{32'hC0A90000, 1'b0, 8'd0,  4'd0},  // R4: one cared bit differs
    '{32'h0A010205, 1'b1, 8'd3,  4'd0}   // R3: entry 4 also matches, 0 wins
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input int idx, input logic [31:0] v, input logic [31:0] c,
                     input logic [7:0] nh, input logic vl);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_value = v; wr_care = c; wr_nh = nh; wr_valid = vl;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [31:0] k);
    @(negedge clk);
    srch_en = 1'b1; srch_key = k;
    @(negedge clk);
    srch_en = 1'b0;
  endtask

  task automatic expect_res(input string req, input logic h, input logic [7:0] nh, input logic [3:0] ix);
    check({req, " vld"}, 32'(res_vld), 32'(1'b1));
    check({req, " hit"}, 32'(res_hit), 32'(h));
    check({req, " nh"},  32'(res_nh),  32'(nh));
    check({req, " idx"}, 32'(res_idx), 32'(ix));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 vld", 32'(res_vld), 0);
    check("R1 hit", 32'(res_hit), 0);
    check("R1 nh", 32'(res_nh), 0);
    rst_n = 1'b1;
    look(32'h0);
    expect_res("R1 empty table", 1'b0, 8'd0, 4'd0);

    // Load routes, longest first
    put(0, 32'h0A010200, 32'hFFFFFF00, 8'd3, 1'b1);
    put(1, 32'h0A010000, 32'hFFFF0000, 8'd5, 1'b1);
    put(2, 32'h0A000000, 32'hFF000000, 8'd7, 1'b1);
    put(3, 32'hC0A80000, 32'hFFFF0000, 8'd9, 1'b1);
    put(4, 32'h00000005, 32'h0000000F, 8'd11, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      look(VEC[i].key);
      expect_res("R2/R3/R4/R8 vector", VEC[i].hit, VEC[i].nh, VEC[i].idx);
    end

    // R5: no lookup, no res_vld
    @(negedge clk);
    check("R5 idle vld", 32'(res_vld), 0);

    // R6: write and lookup in the same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd5; wr_value = 32'h0B000006; wr_care = 32'hFFFFFFFF;
    wr_nh = 8'd13; wr_valid = 1'b1;
    srch_en = 1'b1; srch_key = 32'h0B000006;
    @(negedge clk);
    wr_en = 1'b0;
    expect_res("R6 old contents", 1'b0, 8'd0, 4'd0);
    @(negedge clk);
    srch_en = 1'b0;
    expect_res("R6 new contents", 1'b1, 8'd13, 4'd5);

    // R2/R8: all-wildcard default at the last index
    put(15, 32'hFFFFFFFF, 32'h0, 8'd1, 1'b1);
    look(32'h0B000007);
    expect_res("R2 R8 default route", 1'b1, 8'd1, 4'd15);

    // R7: remove the default, then the /24
    put(15, 32'hFFFFFFFF, 32'h0, 8'd1, 1'b0);
    look(32'h0B000007);
    expect_res("R7 removed default", 1'b0, 8'd0, 4'd0);
    put(0, 32'h0A010200, 32'hFFFFFF00, 8'd3, 1'b0);
    look(32'h0A010203);
    expect_res("R7 fall to /16", 1'b1, 8'd5, 4'd1);

    // R1: reset in mid-run clears the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset hit", 32'(res_hit), 0);
    check("R1 reset idx", 32'(res_idx), 0);
    rst_n = 1'b1;
    look(32'h0A0105FF);
    expect_res("R1 table cleared", 1'b0, 8'd0, 4'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule